// File: doc/BRIEF.md
# Operand Stack with In-Place ALU

This block is the operand store of a zero-address datapath. It holds up to `DEPTH` words of `DW` bits in a last-in, first-out register file. A small arithmetic unit works directly on the entries at the top of the stack, so operands never leave the stack for functional work. A sequencer issues one command per clock with a valid strobe. A push takes a word from the memory-data input. A pop returns the top word on the memory-data output. A unary command rewrites the top entry. A binary command folds the two top entries into one.

Each command has its own guard. A push into a full stack, and a pop, unary or binary command that lacks operands, is refused. A refused command leaves every entry and the occupancy unchanged and raises a one-cycle error pulse. Every strobed command, refused or not, is answered by a one-cycle completion pulse in the cycle after it is accepted. The full and empty flags are registered and always match the occupancy.

Top module: `opstk_top`

## Requirements
- R1: After a synchronous reset the stack is empty: `empty`=1, `full`=0, `done`=0, `overflow`=0, `underflow`=0 and `pop_data`=0. Entries held before the reset are discarded, so a pop that follows reports underflow.
- R2: A push (command code 1) on a stack that is not full stores `push_data` as the new top entry and clears `empty`. `full` rises once `DEPTH` entries are held.
- R3: A push on a full stack writes nothing, pulses `overflow` for one cycle and leaves the contents and `full` as they were.
- R4: A pop (command code 2) on a non-empty stack presents the top entry on `pop_data`, removes it and clears `full`. Words come back in the reverse of their push order. `empty` rises when the last entry is removed, and `pop_data` holds its value until the next accepted pop.
- R5: A pop on an empty stack pulses `underflow` for one cycle and changes neither `pop_data` nor the flags.
- R6: A unary command (code 3) replaces the top entry and keeps the occupancy. The `alu_op` values are 0 for a logical right shift by one, 1 for a bitwise complement, 2 for an increment modulo 2^DW, and 3 for leaving the entry unchanged.
- R7: A binary command (code 4) combines the top entry T and the entry below it U. The result replaces both, and the occupancy drops by one, which clears `full`. The `alu_op` values are 0 for T+U modulo 2^DW, 1 for T AND U, and 2 or 3 for keeping T.
- R8: A unary command on an empty stack, or a binary command with fewer than two entries, pulses `underflow` and changes no state.
- R9: Every cycle with `cmd_valid`=1 produces `done`=1 exactly one cycle later, and `done` is 0 otherwise. `overflow` and `underflow` are never both high and occur only with `done`. Command codes 5 to 7 act as a no-op.
- R10: A no-op (command code 0), or any cycle with `cmd_valid`=0, leaves the entries, the flags and `pop_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per clock |
| cmd | input | 3 | Command code: 0 no-op, 1 push, 2 pop, 3 unary, 4 binary |
| alu_op | input | 2 | Function select for unary and binary commands |
| push_data | input | DW | Word to be pushed |
| pop_data | output | DW | Last popped word (registered) |
| done | output | 1 | One-cycle completion pulse |
| full | output | 1 | Stack holds DEPTH entries |
| empty | output | 1 | Stack holds no entries |
| overflow | output | 1 | One-cycle pulse for a refused push |
| underflow | output | 1 | One-cycle pulse for a command refused for lack of operands |

## Verification
The hardest state to reach from the ports is a binary command issued exactly when the stack is full. The result is written one slot below the last entry, and `full` must drop in the same cycle. Reaching it takes a run of pushes up to capacity, and the bench then reads the folded value back by popping. Refused commands are harder than they look, because their effect can only be seen later. After each refusal, the stimulus therefore pops the stack down and compares the words against the values pushed before the refusal. The stimulus table also runs every unary and binary function code, including the reserved ones, on values whose results differ between the functions.

// File: rtl/opstk_pkg.sv
package opstk_pkg;

  // Command codes on the cmd port
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PUSH   = 3'd1,
    CMD_POP    = 3'd2,
    CMD_UNARY  = 3'd3,
    CMD_BINARY = 3'd4
  } cmd_e;

  // Unary function select
  localparam logic [1:0] UOP_SHR = 2'd0;
  localparam logic [1:0] UOP_NOT = 2'd1;
  localparam logic [1:0] UOP_INC = 2'd2;

  // Binary function select
  localparam logic [1:0] BOP_ADD = 2'd0;
  localparam logic [1:0] BOP_AND = 2'd1;

  // Which slot the write port targets
  typedef enum logic [1:0] {
    WA_PUSH  = 2'd0,  // slot just above the current top
    WA_TOP   = 2'd1,  // current top
    WA_UNDER = 2'd2   // slot below the current top
  } wsel_e;

endpackage

// File: rtl/opstk_guard.sv
module opstk_guard
  import opstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          wr_en,
  output wsel_e         wsel,
  output logic          alu_bin,
  output logic          pop_en,
  output logic          ovf,
  output logic          unf
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] TWO      = CW'(2);

  always_comb begin
    cnt_nxt = cnt;
    wr_en   = 1'b0;
    wsel    = WA_PUSH;
    alu_bin = 1'b0;
    pop_en  = 1'b0;
    ovf     = 1'b0;
    unf     = 1'b0;
    if (cmd_valid) begin
      case (cmd)
        CMD_PUSH: begin
          if (cnt == FULL_CNT) begin
            ovf = 1'b1;
          end else begin
            cnt_nxt = cnt + ONE;
            wr_en   = 1'b1;
            wsel    = WA_PUSH;
          end
        end
        CMD_POP: begin
          if (cnt == '0) begin
            unf = 1'b1;
          end else begin
            cnt_nxt = cnt - ONE;
            pop_en  = 1'b1;
          end
        end
        CMD_UNARY: begin
          if (cnt == '0) begin
            unf = 1'b1;
          end else begin
            wr_en = 1'b1;
            wsel  = WA_TOP;
          end
        end
        CMD_BINARY: begin
          if (cnt < TWO) begin
            unf = 1'b1;
          end else begin
            cnt_nxt = cnt - ONE;
            wr_en   = 1'b1;
            wsel    = WA_UNDER;
            alu_bin = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/opstk_alu.sv
module opstk_alu
  import opstk_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          bin,
  input  logic [1:0]    op,
  input  logic [DW-1:0] top,
  input  logic [DW-1:0] under,
  output logic [DW-1:0] y
);

  always_comb begin
    y = top;
    if (bin) begin
      case (op)
        BOP_ADD: y = top + under;
        BOP_AND: y = top & under;
        default: y = top;
      endcase
    end else begin
      case (op)
        UOP_SHR: y = top >> 1;
        UOP_NOT: y = ~top;
        UOP_INC: y = top + DW'(1);
        default: y = top;
      endcase
    end
  end

endmodule

// File: rtl/opstk_regfile.sv
module opstk_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_top,
  input  logic [AW-1:0] ra_under,
  output logic [DW-1:0] rd_top,
  output logic [DW-1:0] rd_under
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_top   = mem[ra_top];
  assign rd_under = mem[ra_under];

endmodule

// File: rtl/opstk_top.sv
module opstk_top
  import opstk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [1:0]    alu_op,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic          done,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0] cnt_m1, cnt_m2;
  logic [AW-1:0] idx_top, idx_under, idx_push, waddr;
  logic [DW-1:0] rd_top, rd_under, alu_y, wdata;
  logic          wr_en, alu_bin, pop_en, ovf, unf;
  wsel_e         wsel;

  logic [DW-1:0] pop_q;
  logic          done_q, full_q, empty_q, ovf_q, unf_q;

  // Slot indices derived from the occupancy count
  assign cnt_m1    = cnt_q - CW'(1);
  assign cnt_m2    = cnt_q - CW'(2);
  assign idx_top   = cnt_m1[AW-1:0];
  assign idx_under = cnt_m2[AW-1:0];
  assign idx_push  = cnt_q[AW-1:0];

  opstk_guard #(.DEPTH(DEPTH), .CW(CW)) u_guard (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .cnt       (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .wr_en     (wr_en),
    .wsel      (wsel),
    .alu_bin   (alu_bin),
    .pop_en    (pop_en),
    .ovf       (ovf),
    .unf       (unf)
  );

  opstk_alu #(.DW(DW)) u_alu (
    .bin   (alu_bin),
    .op    (alu_op),
    .top   (rd_top),
    .under (rd_under),
    .y     (alu_y)
  );

  always_comb begin
    case (wsel)
      WA_TOP:   waddr = idx_top;
      WA_UNDER: waddr = idx_under;
      default:  waddr = idx_push;
    endcase
  end

  assign wdata = (wsel == WA_PUSH) ? push_data : alu_y;

  opstk_regfile #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rf (
    .clk      (clk),
    .we       (wr_en),
    .waddr    (waddr),
    .wdata    (wdata),
    .ra_top   (idx_top),
    .ra_under (idx_under),
    .rd_top   (rd_top),
    .rd_under (rd_under)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      pop_q   <= '0;
    end else begin
      cnt_q   <= cnt_nxt;
      full_q  <= (cnt_nxt == FULL_CNT);
      empty_q <= (cnt_nxt == '0);
      done_q  <= cmd_valid;
      ovf_q   <= ovf;
      unf_q   <= unf;
      if (pop_en) pop_q <= rd_top;
    end
  end

  assign pop_data  = pop_q;
  assign done      = done_q;
  assign full      = full_q;
  assign empty     = empty_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

endmodule

// File: rtl/opstk_chk.sv
module opstk_chk
  import opstk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [2:0]    cmd,
  input logic [DW-1:0] pop_data,
  input logic          done,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          underflow
);

  // R9
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !done);

  // R9
  single_error_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overflow, underflow}));

  // R9
  error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow || underflow) |-> done);

  // R3
  no_overflow_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_PUSH && full) |=> (overflow && full));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_POP && empty) |=> (underflow && empty && $stable(pop_data)));

  // R2
  push_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_PUSH && !full) |=> (!empty && !overflow));

  // R4
  pop_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_POP && !empty) |=> (!full && !underflow));

  // R7
  binary_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_BINARY && full) |=> (!full && !empty));

  // R4
  pop_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd == CMD_POP) |=> $stable(pop_data));

  // R10
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || cmd == CMD_NOP) |=> ($stable(full) && $stable(empty)));

  // R2
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

endmodule

bind opstk_top opstk_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd       (cmd),
  .pop_data  (pop_data),
  .done      (done),
  .full      (full),
  .empty     (empty),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/sim_opstk_top.sv
`timescale 1ns/1ps
module sim_opstk_top;

  localparam int DW    = 16;
  localparam int DEPTH = 4;

  typedef struct packed {
    logic        v;
    logic [2:0]  c;
    logic [1:0]  op;
    logic [15:0] din;
    logic [15:0] pd;
    logic        fu;
    logic        em;
    logic        ov;
    logic        un;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  // fields: valid, cmd, op, push word, expected pop_data, full, empty, overflow, underflow, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 no-op
    '{1'b1, 3'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 pop empty
    '{1'b1, 3'd3, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 unary empty
    '{1'b1, 3'd1, 2'd0, 16'h0005, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 [5]
    '{1'b1, 3'd4, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 binary one entry
    '{1'b1, 3'd3, 2'd2, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 inc -> [6]
    '{1'b1, 3'd1, 2'd0, 16'h00F3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 [6,F3]
    '{1'b1, 3'd4, 2'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 and -> [2]
    '{1'b1, 3'd1, 2'd0, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 [2,1234]
    '{1'b1, 3'd4, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 add -> [1236]
    '{1'b1, 3'd3, 2'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 not -> [EDC9]
    '{1'b1, 3'd3, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 shr -> [76E4]
    '{1'b1, 3'd3, 2'd3, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 reserved -> [76E4]
    '{1'b1, 3'd1, 2'd0, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd1, 2'd0, 16'h0002, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd1, 2'd0, 16'h0003, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 full
    '{1'b1, 3'd1, 2'd0, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 overflow
    '{1'b0, 3'd1, 2'd0, 16'hAAAA, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 no strobe
    '{1'b1, 3'd2, 2'd0, 16'h0000, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 pop 3 (not BEEF)
    '{1'b1, 3'd4, 2'd2, 16'h0000, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 keep top -> [76E4,2]
    '{1'b1, 3'd2, 2'd0, 16'h0000, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 pop 2
    '{1'b1, 3'd6, 2'd0, 16'h0000, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 code 6 no-op
    '{1'b1, 3'd2, 2'd0, 16'h0000, 16'h76E4, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 last entry
    '{1'b1, 3'd2, 2'd0, 16'h0000, 16'h76E4, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5}   // R5 pop empty
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic [1:0]    alu_op = 2'd0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic          done, full, empty, overflow, underflow;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  opstk_top #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .alu_op    (alu_op),
    .push_data (push_data),
    .pop_data  (pop_data),
    .done      (done),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .underflow (underflow)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Drive a command right after a falling edge; outputs are sampled at the next falling edge
  task automatic issue(logic v, logic [2:0] c, logic [1:0] op, logic [15:0] d);
    cmd_valid = v;
    cmd       = c;
    alu_op    = op;
    push_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd       = 3'd0;
  endtask

  task automatic check_idle_state(string req);
    check(req, "done", int'(done), 0);
    check(req, "full", int'(full), 0);
    check(req, "empty", int'(empty), 1);
    check(req, "overflow", int'(overflow), 0);
    check(req, "underflow", int'(underflow), 0);
    check(req, "pop_data", int'(pop_data), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state straight after reset
    check_idle_state("R1");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].rq);
      issue(VECS[i].v, VECS[i].c, VECS[i].op, VECS[i].din);
      check(tag, $sformatf("vec%0d done", i), int'(done), int'(VECS[i].v));
      check(tag, $sformatf("vec%0d full", i), int'(full), int'(VECS[i].fu));
      check(tag, $sformatf("vec%0d empty", i), int'(empty), int'(VECS[i].em));
      check(tag, $sformatf("vec%0d overflow", i), int'(overflow), int'(VECS[i].ov));
      check(tag, $sformatf("vec%0d underflow", i), int'(underflow), int'(VECS[i].un));
      check(tag, $sformatf("vec%0d pop_data", i), int'(pop_data), int'(VECS[i].pd));
    end

    // R7: binary on a full stack folds the top two and clears full
    issue(1'b1, 3'd1, 2'd0, 16'h000A);
    issue(1'b1, 3'd1, 2'd0, 16'h0014);
    issue(1'b1, 3'd1, 2'd0, 16'h001E);
    issue(1'b1, 3'd1, 2'd0, 16'h0028);
    check("R2", "full after DEPTH pushes", int'(full), 1);
    issue(1'b1, 3'd4, 2'd0, 16'h0000);
    check("R7", "full after binary", int'(full), 0);
    check("R7", "underflow after binary", int'(underflow), 0);
    issue(1'b1, 3'd2, 2'd0, 16'h0000);
    check("R7", "folded sum", int'(pop_data), 16'h0046);
    issue(1'b1, 3'd2, 2'd0, 16'h0000);
    check("R4", "second pop", int'(pop_data), 16'h0014);
    issue(1'b1, 3'd2, 2'd0, 16'h0000);
    check("R4", "third pop", int'(pop_data), 16'h000A);
    check("R4", "empty after last pop", int'(empty), 1);

    // R1: reset in the middle of use discards entries
    issue(1'b1, 3'd1, 2'd0, 16'h0111);
    issue(1'b1, 3'd1, 2'd0, 16'h0222);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle_state("R1");
    issue(1'b1, 3'd2, 2'd0, 16'h0000);
    check("R1", "pop after reset underflow", int'(underflow), 1);
    check("R1", "pop after reset data", int'(pop_data), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule